// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block runs the multi-command sequences that erase a serial NOR flash or read its identity. It sends them through a byte-level command engine, which handles the actual wire timing. A single start pulse, together with an operation select and a 24-bit address, launches one operation. For an erase, the sequencer first unlocks writes. It then sends the erase opcode, with the address bytes when the erase covers a region. After that it waits and reads the status byte repeatedly until the device reports that it is idle.

Each request to the engine carries a byte count to send, a byte count to read back, and a packed byte array. The request stays asserted until the engine acknowledges it. Whole-device, block and sector erases take very different times to finish. For that reason, each erase class has its own wait between status reads, given in clock cycles. A poll budget bounds the total wait and reports an error if the device never becomes idle. A done pulse ends every accepted operation. For an identity read, the three returned bytes are presented on a separate output.

Top module: `spi_erase_seq`

## Requirements
- R1: After reset, busy_o, req_o, done_o and err_o are all 0.
- R2: op_i = 0 issues one request with opcode 0x9F, write count 1 and read count 3. Afterwards id_o[23:16] holds the first received byte (rdata_i[7:0]), and id_o[15:0] holds the model value, with the second received byte in the high half and the third in the low half.
- R3: Every erase (op_i 1 to 5) begins with a request carrying opcode 0x06, write count 1 and read count 0.
- R4: op_i = 1 sends whole-device erase 0x60 and op_i = 2 sends 0xC7, each with write count 1 and read count 0.
- R5: op_i = 3 sends 0x52, op_i = 4 sends 0xD8 and op_i = 5 sends 0x20, each with write count 4 and read count 0. Byte k of a request sits in req_wdata_o[8k+7:8k]. Byte 0 is the opcode, and bytes 1, 2 and 3 are address bits 23:16, 15:8 and 7:0.
- R6: After the erase command, status reads (opcode 0x05, write count 1, read count 1) repeat while rdata_i bit 0 is 1. The first read with bit 0 at 0 ends the operation with a one-cycle done_o pulse, err_o at 0, and no further requests. The other status bits have no effect.
- R7: Between the acknowledge of the erase command or of a busy status read and the next status request, at least the class wait passes and at most that wait plus 3 cycles. The class wait is CHIP_WAIT for op 1 and 2, BLOCK_WAIT for op 3 and 4, and SECTOR_WAIT for op 5.
- R8: If MAX_POLLS status reads all return bit 0 at 1, the operation ends with done_o and err_o both 1 for one cycle, and no further requests follow.
- R9: A start_i pulse while busy_o is 1 is ignored, and so is a start with op_i 6 or 7. No request is issued and busy_o does not rise.
- R10: While req_o is 1 and ack_i is 0, req_o stays 1 on the next cycle, with unchanged counts and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches an operation when idle |
| op_i | input | 3 | Operation select (0 ID, 1/2 device erase, 3/4 block, 5 sector) |
| addr_i | input | 24 | Erase address, captured at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With done_o: status never showed idle |
| id_o | output | 24 | Identity bytes from the last ID read |
| req_o | output | 1 | Command request to the engine |
| req_wcnt_o | output | 3 | Bytes to send |
| req_rcnt_o | output | 2 | Bytes to read back |
| req_wdata_o | output | 32 | Bytes to send, byte 0 lowest |
| ack_i | input | 1 | Engine finished the current request |
| rdata_i | input | 24 | Bytes read back, first byte lowest |

## Verification
All six operation selects are run against an engine model, and each one's expected command stream is compared byte for byte. This separates the two opcodes in each erase class and shows whether address bytes are attached. Erases are run with zero, one and two busy status replies, and with a device that stays busy forever. These runs separate a normal finish from a timeout and confirm that only status bit 0 is decoded. The measured gap before each status read is checked against three distinct class waits, which shows that each class uses its own interval. A start pulse during an erase and a start with an unused select show that no stray command reaches the engine.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_ERASE,
        ST_WAIT,
        ST_POLL,
        ST_RDID
    } seq_state_e;

    typedef enum logic [1:0] {
        CLS_CHIP,
        CLS_BLOCK,
        CLS_SECTOR,
        CLS_NONE
    } erase_cls_e;

    localparam logic [2:0] SEL_ID    = 3'd0;
    localparam logic [2:0] SEL_CE_A  = 3'd1;
    localparam logic [2:0] SEL_CE_B  = 3'd2;
    localparam logic [2:0] SEL_BE_A  = 3'd3;
    localparam logic [2:0] SEL_BE_B  = 3'd4;
    localparam logic [2:0] SEL_SE    = 3'd5;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_STAT  = 8'h05;
    localparam logic [7:0] OPC_IDENT = 8'h9F;

    function automatic erase_cls_e sel_class(input logic [2:0] sel);
        case (sel)
            SEL_CE_A, SEL_CE_B: return CLS_CHIP;
            SEL_BE_A, SEL_BE_B: return CLS_BLOCK;
            SEL_SE:             return CLS_SECTOR;
            default:            return CLS_NONE;
        endcase
    endfunction

    function automatic logic [7:0] sel_opcode(input logic [2:0] sel);
        case (sel)
            SEL_CE_A: return 8'h60;
            SEL_CE_B: return 8'hC7;
            SEL_BE_A: return 8'h52;
            SEL_BE_B: return 8'hD8;
            SEL_SE:   return 8'h20;
            default:  return OPC_IDENT;
        endcase
    endfunction

    function automatic logic sel_known(input logic [2:0] sel);
        return (sel == SEL_ID) || (sel_class(sel) != CLS_NONE);
    endfunction

endpackage

// File: rtl/spi_erase_cmdfmt.sv
module spi_erase_cmdfmt
    import spi_erase_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NBYTES = ADDR_W / 8 + 1
) (
    input  seq_state_e              state_i,
    input  logic [2:0]              sel_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic [2:0]              wcnt_o,
    output logic [1:0]              rcnt_o,
    output logic [8*NBYTES-1:0]     wdata_o
);
    localparam int ABYTES = ADDR_W / 8;

    // address bytes, most significant first on the wire
    logic [8*ABYTES-1:0] addr_seq;
    for (genvar b = 0; b < ABYTES; b++) begin : g_abyte
        assign addr_seq[8*b +: 8] = addr_i[ADDR_W-8-8*b +: 8];
    end

    always_comb begin
        wcnt_o  = 3'd0;
        rcnt_o  = 2'd0;
        wdata_o = '0;
        case (state_i)
            ST_WREN: begin
                wdata_o[7:0] = OPC_WREN;
                wcnt_o       = 3'd1;
            end
            ST_ERASE: begin
                wdata_o[7:0] = sel_opcode(sel_i);
                if (sel_class(sel_i) == CLS_CHIP) begin
                    wcnt_o = 3'd1;
                end else begin
                    wdata_o[8*NBYTES-1:8] = addr_seq;
                    wcnt_o                = 3'(NBYTES);
                end
            end
            ST_POLL: begin
                wdata_o[7:0] = OPC_STAT;
                wcnt_o       = 3'd1;
                rcnt_o       = 2'd1;
            end
            ST_RDID: begin
                wdata_o[7:0] = OPC_IDENT;
                wcnt_o       = 3'd1;
                rcnt_o       = 2'd3;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_erase_timer.sv
module spi_erase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
    import spi_erase_pkg::*;
#(
    parameter int CHIP_WAIT   = 100000,
    parameter int BLOCK_WAIT  = 10000,
    parameter int SECTOR_WAIT = 1000,
    parameter int MAX_POLLS   = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [2:0]  op_i,
    input  logic [23:0] addr_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [23:0] id_o,
    output logic        req_o,
    output logic [2:0]  req_wcnt_o,
    output logic [1:0]  req_rcnt_o,
    output logic [31:0] req_wdata_o,
    input  logic        ack_i,
    input  logic [23:0] rdata_i
);
    localparam int ADDR_W  = 24;
    localparam int NBYTES  = ADDR_W / 8 + 1;
    localparam int MAXWAIT = (CHIP_WAIT > BLOCK_WAIT)
                           ? ((CHIP_WAIT > SECTOR_WAIT) ? CHIP_WAIT : SECTOR_WAIT)
                           : ((BLOCK_WAIT > SECTOR_WAIT) ? BLOCK_WAIT : SECTOR_WAIT);
    localparam int TW      = $clog2(MAXWAIT + 2);
    localparam int PW      = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [2:0]        sel;
        logic [ADDR_W-1:0] addr;
        logic [PW-1:0]     polls;
        logic              done;
        logic              err;
        logic [23:0]       id;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    always_comb begin
        case (sel_class(r_q.sel))
            CLS_CHIP:  tmr_val = TW'(CHIP_WAIT);
            CLS_BLOCK: tmr_val = TW'(BLOCK_WAIT);
            default:   tmr_val = TW'(SECTOR_WAIT);
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        tmr_load = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i && sel_known(op_i)) begin
                    r_d.sel   = op_i;
                    r_d.addr  = addr_i;
                    r_d.polls = '0;
                    r_d.state = (op_i == SEL_ID) ? ST_RDID : ST_WREN;
                end
            end
            ST_WREN: if (ack_i) r_d.state = ST_ERASE;
            ST_ERASE: begin
                if (ack_i) begin
                    r_d.state = ST_WAIT;
                    tmr_load  = 1'b1;
                end
            end
            ST_WAIT: if (tmr_zero) r_d.state = ST_POLL;
            ST_POLL: begin
                if (ack_i) begin
                    if (!rdata_i[0]) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else if (r_q.polls == PW'(MAX_POLLS - 1)) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                    end else begin
                        r_d.polls = r_q.polls + 1'b1;
                        r_d.state = ST_WAIT;
                        tmr_load  = 1'b1;
                    end
                end
            end
            ST_RDID: begin
                if (ack_i) begin
                    r_d.id    = {rdata_i[7:0], rdata_i[15:8], rdata_i[23:16]};
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    spi_erase_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    spi_erase_cmdfmt #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_fmt (
        .state_i (r_q.state),
        .sel_i   (r_q.sel),
        .addr_i  (r_q.addr),
        .wcnt_o  (req_wcnt_o),
        .rcnt_o  (req_rcnt_o),
        .wdata_o (req_wdata_o)
    );

    assign req_o  = (r_q.state == ST_WREN) || (r_q.state == ST_ERASE) ||
                    (r_q.state == ST_POLL) || (r_q.state == ST_RDID);
    assign busy_o = (r_q.state != ST_IDLE);
    assign done_o = r_q.done;
    assign err_o  = r_q.err;
    assign id_o   = r_q.id;

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> req_o && $stable(req_wdata_o) && $stable(req_wcnt_o) && $stable(req_rcnt_o));

    a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r8_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    a_r6_done_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !req_o);

    a_r6_no_req_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && req_wdata_o[7:0] == OPC_STAT && rdata_i[0] && busy_o) |=> !req_o || done_o == 1'b0);

endmodule

// File: tb/tb_spi_erase_seq.sv
module tb_spi_erase_seq;
    localparam int CLK_PERIOD  = 10;
    localparam int CHIP_WAIT   = 30;
    localparam int BLOCK_WAIT  = 15;
    localparam int SECTOR_WAIT = 5;
    localparam int MAX_POLLS   = 4;
    localparam int LAT         = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [23:0] addr_i = 24'd0;
    logic        busy_o, done_o, err_o, req_o, ack_i;
    logic [23:0] id_o, rdata_i;
    logic [2:0]  req_wcnt_o;
    logic [1:0]  req_rcnt_o;
    logic [31:0] req_wdata_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int busy_left = 0;
    int cur_wait  = 0;
    int gap_min   = -1;
    int last_ack  = 0;
    logic [23:0] id_val = 24'hC22017;

    logic [36:0] exp_q[$];
    string       tag_q[$];

    spi_erase_seq #(
        .CHIP_WAIT(CHIP_WAIT), .BLOCK_WAIT(BLOCK_WAIT),
        .SECTOR_WAIT(SECTOR_WAIT), .MAX_POLLS(MAX_POLLS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .id_o(id_o),
        .req_o(req_o), .req_wcnt_o(req_wcnt_o), .req_rcnt_o(req_rcnt_o),
        .req_wdata_o(req_wdata_o), .ack_i(ack_i), .rdata_i(rdata_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] w, input logic [1:0] rc, input logic [31:0] d, input string tag);
        exp_q.push_back({w, rc, d});
        tag_q.push_back(tag);
    endtask

    // engine model and scoreboard monitor
    initial begin
        ack_i = 1'b0;
        rdata_i = '0;
        forever begin
            @(negedge clk);
            ack_i = 1'b0;
            if (rst_n && req_o) begin
                logic [36:0] item;
                item = {req_wcnt_o, req_rcnt_o, req_wdata_o};
                if (req_wdata_o[7:0] == 8'h05 && gap_min >= 0)
                    check((cyc - last_ack) >= gap_min && (cyc - last_ack) <= gap_min + 3,
                          "R7", "poll interval", 64'(cyc - last_ack), 64'(gap_min));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected command", 64'(item), 64'd0);
                end else begin
                    logic [36:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(item == e, t, "command", 64'(item), 64'(e));
                end
                repeat (LAT) @(negedge clk);
                if (req_wdata_o[7:0] == 8'h05) begin
                    rdata_i = (busy_left > 0) ? 24'h000003 : 24'hFFFFFE;
                    if (busy_left > 0) busy_left--;
                end else if (req_wdata_o[7:0] == 8'h9F) begin
                    rdata_i = id_val;
                end else begin
                    rdata_i = 24'h0;
                end
                if (req_wdata_o[7:0] == 8'h05 || (req_wdata_o[7:0] != 8'h06 && req_wdata_o[7:0] != 8'h9F))
                    gap_min = cur_wait;
                else
                    gap_min = -1;
                ack_i = 1'b1;
                last_ack = cyc;
            end
        end
    end

    task automatic run_op(input logic [2:0] op, input logic [23:0] addr, input int busy_reads,
                          input bit exp_err, input bit poke, input string tag);
        logic [7:0] opc;
        int n;
        bit seen;
        seen = 0;
        case (op)
            3'd1: begin opc = 8'h60; cur_wait = CHIP_WAIT; end
            3'd2: begin opc = 8'hC7; cur_wait = CHIP_WAIT; end
            3'd3: begin opc = 8'h52; cur_wait = BLOCK_WAIT; end
            3'd4: begin opc = 8'hD8; cur_wait = BLOCK_WAIT; end
            default: begin opc = 8'h20; cur_wait = SECTOR_WAIT; end
        endcase
        if (op == 3'd0) begin
            push(3'd1, 2'd3, 32'h9F, "R2");
        end else begin
            push(3'd1, 2'd0, 32'h06, "R3");
            if (op <= 3'd2)
                push(3'd1, 2'd0, {24'h0, opc}, "R4");
            else
                push(3'd4, 2'd0, {addr[7:0], addr[15:8], addr[23:16], opc}, "R5");
            n = exp_err ? MAX_POLLS : busy_reads + 1;
            for (int i = 0; i < n; i++) push(3'd1, 2'd1, 32'h05, "R6");
        end
        busy_left = busy_reads;
        @(negedge clk);
        start_i = 1'b1; op_i = op; addr_i = addr;
        @(negedge clk);
        start_i = 1'b0; op_i = 3'd0;
        if (poke) begin
            repeat (8) @(negedge clk);
            start_i = 1'b1;           // R9: must be ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1;
                check(err_o == exp_err, exp_err ? "R8" : "R6", "err flag", 64'(err_o), 64'(exp_err));
                check(busy_o == 1'b0, "R6", "busy at done", 64'(busy_o), 64'd0);
                if (op == 3'd0)
                    check(id_o == {id_val[7:0], id_val[15:8], id_val[23:16]}, "R2", "id value",
                          64'(id_o), 64'({id_val[7:0], id_val[15:8], id_val[23:16]}));
            end
        end
        check(seen, tag, "done pulse seen", 64'(seen), 64'd1);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, tag, "commands left", 64'(exp_q.size()), 64'd0);
        check(req_o == 1'b0 && busy_o == 1'b0, tag, "quiet after done", 64'({req_o, busy_o}), 64'd0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 0 && req_o == 0 && done_o == 0 && err_o == 0, "R1", "reset outputs",
              64'({busy_o, req_o, done_o, err_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && req_o == 0 && done_o == 0 && err_o == 0, "R1", "after release",
              64'({busy_o, req_o, done_o, err_o}), 64'd0);

        run_op(3'd0, 24'h0, 0, 1'b0, 1'b0, "R2");
        run_op(3'd1, 24'h0, 2, 1'b0, 1'b0, "R4");
        run_op(3'd2, 24'h0, 0, 1'b0, 1'b0, "R4");
        run_op(3'd3, 24'h123456, 1, 1'b0, 1'b0, "R5");
        run_op(3'd4, 24'hFEDCBA, 0, 1'b0, 1'b1, "R9");
        run_op(3'd5, 24'hABCDEF, 2, 1'b0, 1'b1, "R7");
        run_op(3'd5, 24'h000100, 100, 1'b1, 1'b0, "R8");

        // R9: unused selects never start
        for (int s = 6; s < 8; s++) begin
            @(negedge clk);
            start_i = 1'b1; op_i = 3'(s);
            @(negedge clk);
            start_i = 1'b0; op_i = 3'd0;
            repeat (10) @(negedge clk);
            check(busy_o == 1'b0 && req_o == 1'b0, "R9", "unused select ignored",
                  64'({busy_o, req_o}), 64'd0);
        end

        // ID read again with another value after erases
        id_val = 24'h5A1234;
        run_op(3'd0, 24'h0, 0, 1'b0, 1'b0, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule